// File: doc/BRIEF.md
# Synchronous Bus Read Master

This block runs single read transfers on a clocked parallel memory bus with active-low strobes. A local client asks for a read by pulsing a request together with an address. The controller then works through the transfer in a fixed order. It puts the address on the bus for one cycle with the strobes inactive, so the memory's address decode has time to settle. It then pulls the memory-request and read strobes low together and keeps them low while the memory signals through its active-low wait line that data is not ready yet. It takes the data on the clock edge at which the wait line is released. In the following cycle it raises the strobes and returns the captured word with a one-cycle response pulse.

Each response also reports how many wait states the memory inserted. Requests are taken only while the controller is idle. Anything presented while a transfer is in progress is dropped.

Top module: `sync_rd_master`

## Requirements
- R1: While reset is held, and after its release until a request arrives, `mreq_no` and `rd_no` are 1, `busy_o` is 0 and `rsp_valid_o` is 0.
- R2: A request is accepted on a clock edge with `req_valid_i`=1 while idle. In the next cycle `bus_addr_o` carries the requested address with both strobes still 1. The strobes fall in the cycle after that, with the address unchanged.
- R3: `mreq_no` and `rd_no` are equal in every cycle.
- R4: With `wait_ni` high, the strobes are low for exactly one cycle. `rsp_valid_o` is 1 in the third cycle after the accepting edge.
- R5: Every clock edge with the strobes low and `wait_ni`=0 keeps the strobes low for one more cycle. It also delays the response by one cycle.
- R6: Data is sampled from `bus_data_i` on the edge at which the strobes are low and `wait_ni`=1. `rsp_data_o` shows that word in the response cycle.
- R7: `rsp_valid_o` lasts exactly one cycle, and both strobes are 1 during it.
- R8: In the response cycle, `rsp_waits_o` equals the number of wait edges in the transfer, saturating at 2^WCNT_W-1.
- R9: A `req_valid_i` pulse seen while `busy_o`=1 is ignored: the address and data of the running transfer are unaffected, and no further transfer follows. `busy_o` is 1 from the cycle after acceptance through the response cycle and 0 after it.
- R10: `bus_addr_o` stays stable for every cycle in which the strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request pulse |
| req_addr_i | input | ADDR_W | Read address, sampled with the request |
| busy_o | output | 1 | Transfer in progress |
| bus_addr_o | output | ADDR_W | Bus address |
| mreq_no | output | 1 | Memory request strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| wait_ni | input | 1 | Memory wait request, active low |
| bus_data_i | input | DATA_W | Bus read data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_data_o | output | DATA_W | Captured read data |
| rsp_waits_o | output | WCNT_W | Wait states inserted in the transfer |

## Verification
The bench builds the block with a 12-bit address, a 16-bit data word and a 4-bit wait counter. The narrow counter lets a transfer of 20 wait states drive the count past its ceiling of 15 within a few dozen cycles. Meanwhile, random wait lengths from zero to six check the cycle-exact response latency. The memory model drives garbage on the data lines while it is stalling, so sampling on the wrong edge shows up as a data mismatch. A request pulse injected during the address phase checks that requests made while busy are dropped.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STROBE,
    ST_WAIT,
    ST_DATA
  } srm_state_e;
endpackage

// File: rtl/srm_ctrl.sv
module srm_ctrl
  import srm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic wait_ni,
  output logic accept_o,
  output logic capture_o,
  output logic wait_hit_o,
  output logic strobe_o,
  output logic done_o,
  output logic busy_o
);
  srm_state_e state_q, state_d;
  logic in_access;

  assign in_access  = (state_q == ST_STROBE) || (state_q == ST_WAIT);
  assign accept_o   = (state_q == ST_IDLE) && req_valid_i;
  assign capture_o  = in_access && wait_ni;
  assign wait_hit_o = in_access && !wait_ni;
  assign strobe_o   = in_access;
  assign done_o     = (state_q == ST_DATA);
  assign busy_o     = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_ADDR;
      ST_ADDR:   state_d = ST_STROBE;
      ST_STROBE,
      ST_WAIT:   state_d = wait_ni ? ST_DATA : ST_WAIT;
      ST_DATA:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/srm_wait_cnt.sv
module srm_wait_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i)                   cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/srm_capture.sv
module srm_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // address held from acceptance until the next acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (accept_i) addr_q <= addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (capture_i) data_q <= data_i;
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/sync_rd_master.sv
module sync_rd_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              mreq_no,
  output logic              rd_no,
  input  logic              wait_ni,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [WCNT_W-1:0] rsp_waits_o
);
  logic accept, capture, wait_hit, strobe, done, busy;

  srm_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .wait_ni     (wait_ni),
    .accept_o    (accept),
    .capture_o   (capture),
    .wait_hit_o  (wait_hit),
    .strobe_o    (strobe),
    .done_o      (done),
    .busy_o      (busy)
  );

  srm_wait_cnt #(.CNT_W(WCNT_W)) u_wcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .inc_i   (wait_hit),
    .count_o (rsp_waits_o)
  );

  srm_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (req_addr_i),
    .capture_i (capture),
    .data_i    (bus_data_i),
    .addr_o    (bus_addr_o),
    .data_o    (rsp_data_o)
  );

  assign mreq_no     = ~strobe;
  assign rd_no       = ~strobe;
  assign rsp_valid_o = done;
  assign busy_o      = busy;
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WCNT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              mreq_no,
  input logic              rd_no,
  input logic              wait_ni,
  input logic [DATA_W-1:0] bus_data_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic [WCNT_W-1:0] rsp_waits_o
);
  localparam logic [15:0] WMAX = 16'((1 << WCNT_W) - 1);

  logic [15:0] seen_waits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_waits <= '0;
    else if (!mreq_no && !wait_ni) begin
      if (seen_waits != 16'hFFFF) seen_waits <= seen_waits + 16'd1;
    end else if (rsp_valid_o) seen_waits <= '0;
  end

  assert_addr_before_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mreq_no) |-> ($past(busy_o) && $stable(bus_addr_o)));

  assert_addr_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_no && $past(!mreq_no)) |-> $stable(bus_addr_o));

  assert_wait_extends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_no && !wait_ni) |=> (!mreq_no && !rsp_valid_o));

  assert_sample_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_no && wait_ni) |=> (rsp_valid_o && rsp_data_o == $past(bus_data_i)));

  assert_pulse_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_strobes_off_in_rsp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (mreq_no && rd_no));

  assert_wait_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (16'(rsp_waits_o) == ((seen_waits > WMAX) ? WMAX : seen_waits)));

  assert_busy_ignores_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && busy_o && !rsp_valid_o) |=> (busy_o && $stable(bus_addr_o)));
endmodule

bind sync_rd_master srm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WCNT_W(WCNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .busy_o      (busy_o),
  .bus_addr_o  (bus_addr_o),
  .mreq_no     (mreq_no),
  .rd_no       (rd_no),
  .wait_ni     (wait_ni),
  .bus_data_i  (bus_data_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_data_o  (rsp_data_o),
  .rsp_waits_o (rsp_waits_o)
);

// File: tb/sim_sync_rd_master.sv
`timescale 1ns/1ps
module sim_sync_rd_master;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          busy;
  logic [AW-1:0] bus_addr;
  logic          mreq_n, rd_n;
  logic          wait_n = 1'b1;
  logic [DW-1:0] bus_data = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [CW-1:0] rsp_waits;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sync_rd_master #(.ADDR_W(AW), .DATA_W(DW), .WCNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .busy_o(busy), .bus_addr_o(bus_addr), .mreq_no(mreq_n), .rd_no(rd_n),
    .wait_ni(wait_n), .bus_data_i(bus_data), .rsp_valid_o(rsp_valid),
    .rsp_data_o(rsp_data), .rsp_waits_o(rsp_waits)
  );

  function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] a);
    return (16'(a) * 16'h9E37) ^ 16'h5A5A;
  endfunction

  function automatic int exp_waits(input int nw);
    return (nw > CMAX) ? CMAX : nw;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: holds wait_n low for cur_nw strobe cycles, drives junk meanwhile
  int            cur_nw = 0;
  logic [AW-1:0] cur_addr = '0;
  int            low_cnt = 0;
  int            last_low = 0;
  bit            prev_mreq = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  bit            addr_bad = 1'b0;
  bit            rd_bad = 1'b0;

  always @(negedge clk) begin
    if (mreq_n !== rd_n) rd_bad = 1'b1;
    if (!rst_n) begin
      wait_n  = 1'b1;
      low_cnt = 0;
    end else if (!mreq_n) begin
      if (bus_addr != cur_addr) addr_bad = 1'b1;
      if (prev_mreq && prev_addr != cur_addr) addr_bad = 1'b1;
      wait_n = (low_cnt >= cur_nw);
      low_cnt++;
    end else begin
      wait_n = 1'b1;
      if (low_cnt != 0) last_low = low_cnt;
      low_cnt = 0;
    end
    bus_data  = wait_n ? exp_data(bus_addr) : DW'($urandom);
    prev_mreq = mreq_n;
    prev_addr = bus_addr;
  end

  task automatic do_read(input logic [AW-1:0] a, input int nw, input bit intrude);
    int k;
    int got;
    logic [DW-1:0] d;
    logic [CW-1:0] w;
    bit strobe_in_rsp;
    @(negedge clk);
    cur_nw = nw; cur_addr = a; addr_bad = 1'b0; rd_bad = 1'b0;
    req_valid = 1'b1; req_addr = a;
    k = 0; got = -1; d = '0; w = '0; strobe_in_rsp = 1'b0;
    while (got < 0 && k < nw + 12) begin
      @(negedge clk);
      k++;
      req_valid = 1'b0;
      if (intrude && k == 1) begin
        req_valid = 1'b1;
        req_addr  = ~a;
      end
      if (k == 1) check(busy == 1'b1 && mreq_n == 1'b1 && bus_addr == a, "R2 addr phase", bus_addr, a);
      if (rsp_valid) begin
        got = k; d = rsp_data; w = rsp_waits;
        strobe_in_rsp = !mreq_n || !rd_n;
      end
    end
    check(got == 3 + nw, (nw == 0) ? "R4 latency" : "R5 latency", got, 3 + nw);
    check(d == exp_data(a), "R6 data", d, exp_data(a));
    check(int'(w) == exp_waits(nw), "R8 wait count", w, exp_waits(nw));
    check(!strobe_in_rsp, "R7 strobes high in response", strobe_in_rsp, 0);
    @(negedge clk);
    check(!rsp_valid, "R7 single pulse", rsp_valid, 0);
    check(!busy, "R9 idle after response", busy, 0);
    check(last_low == nw + 1, (nw == 0) ? "R4 strobe width" : "R5 strobe width", last_low, nw + 1);
    check(!addr_bad, "R10 address held", addr_bad, 0);
    check(!rd_bad, "R3 strobes equal", rd_bad, 0);
    if (intrude) begin
      repeat (3) @(negedge clk);
      check(mreq_n && !busy, "R9 no extra transfer", mreq_n, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(mreq_n && rd_n && !busy && !rsp_valid, "R1 reset state", {mreq_n, rd_n, busy, rsp_valid}, 4'b1100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mreq_n && rd_n && !busy && !rsp_valid, "R1 after release", {mreq_n, rd_n, busy, rsp_valid}, 4'b1100);
    do_read(12'h000, 0, 1'b0);
    do_read(12'hFFF, 1, 1'b0);
    do_read(12'h123, CMAX, 1'b0);
    do_read(12'hABC, 20, 1'b0);
    do_read(12'h5A5, 2, 1'b1);
    for (int i = 0; i < 40; i++) begin
      do_read(AW'($urandom), int'($urandom % 7), (i % 9) == 4);
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule